// File: doc/BRIEF.md
# Paper-Tape Punch Peripheral Slot

This block sits in one I/O slot of a word-oriented processor and drives a paper-tape punch mechanism. The processor writes a character with an output-data strobe. The eight bits of the character drive the punch coil enables. A set-control strobe then raises the punch command. The mechanism answers with a flag pulse once the character is punched. That pulse drops the punch command and sets the slot's flag state.

The processor can wait for the character in one of two ways. In the first, it enables interrupts by setting the control flip-flop, and the slot raises an interrupt request during CPU timing phase T2. In the second, it polls with a skip-if-flag-set strobe, which answers on the skip line while the flag is set. A load-input strobe returns the low-tape alarm as a status bit.

The mechanism's flag and alarm lines are asynchronous, so each passes through a two-stage synchronizer. The flag is acted on only at its rising edge.

Top module: `punch_iface`

## Requirements
- R1: An output-data strobe sampled at a clock edge loads `dataIn` into the data register. From that edge onward, `coilEn` equals the loaded byte.
- R2: A set-control strobe sets the control flip-flop and raises `punchCmd` at the same edge. A clear-control strobe clears the control flip-flop and the interrupt-request flip-flop, but leaves `punchCmd` as it is. If both strobes arrive together, clear-control wins for the control flip-flop, and `punchCmd` is still raised.
- R3: If set-control and clear-flag arrive in the same cycle, the flag flip-flop and the flag buffer end up cleared. No interrupt request follows until the next flag edge.
- R4: A rising edge on `punchFlagIn` is seen three clock edges after the pin goes high (two synchronizer stages plus edge detection). At that edge it clears `punchCmd` and sets both the flag buffer and the flag flip-flop. A pin held high acts only once. A set-control strobe at that same edge keeps `punchCmd` high.
- R5: At a clock edge where `phaseT2` is high and both the flag buffer and the control flip-flop are set, the interrupt-request flip-flop sets. `irqOut` and `flagOut` both follow it. It stays set until a clear-control strobe or a reset.
- R6: A set-flag strobe sets both the flag buffer and the flag flip-flop. A clear-flag strobe clears both, and it wins over a set-flag strobe or a flag edge in the same cycle.
- R7: `skipOut` is high exactly while `strbSkip` is high and the flag flip-flop is set. It is combinational in the present cycle.
- R8: While `strbLoad` is high, bit 5 of `dataOut` carries the low-tape alarm, taken two clock edges after the pin changes. All other bits of `dataOut` are zero. While `strbLoad` is low, `dataOut` is all zero.
- R9: An active-low reset clears the data register, the control, punch, flag-buffer, flag and interrupt-request flip-flops, and both synchronizers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strbOut | input | 1 | Output-data strobe |
| strbSetCtl | input | 1 | Set-control strobe |
| strbClrCtl | input | 1 | Clear-control strobe |
| strbSetFlg | input | 1 | Set-flag strobe |
| strbClrFlg | input | 1 | Clear-flag strobe |
| strbSkip | input | 1 | Skip-if-flag-set strobe |
| strbLoad | input | 1 | Load-input strobe |
| dataIn | input | 8 | Low byte of the CPU register |
| phaseT2 | input | 1 | CPU timing phase T2 indicator |
| dataOut | output | 8 | Input word returned to the CPU |
| skipOut | output | 1 | Skip answer |
| flagOut | output | 1 | Flag line toward the CPU |
| irqOut | output | 1 | Interrupt request toward the CPU |
| coilEn | output | 8 | Punch coil enables |
| punchCmd | output | 1 | Punch command to the mechanism |
| punchFlagIn | input | 1 | Flag pulse from the mechanism (asynchronous) |
| lowTapeIn | input | 1 | Low-tape alarm (asynchronous) |

## Verification
The assertions assume that the CPU strobes and `phaseT2` are synchronous to `clk`. They also assume that the flag and alarm pins are only meaningful after they pass through the synchronizers, so every property refers to the synchronized edge and never to the raw pin. The bench drives every input on the falling edge, which keeps the strobes synchronous. It holds the flag pin at each level for several cycles so that each pulse gives exactly one detected edge. Strobes fire at a low random rate, so the flip-flop states persist long enough for the T2 sampling and the polling path to be reached.

// File: rtl/tpPkg.sv
package tpPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadData;
    logic readStatus;
  } dpCtl_t;
endpackage

// File: rtl/punch_datapath.sv
module punch_datapath #(
  parameter int DATA_W      = 8,
  parameter int STATUS_BIT  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  tpPkg::dpCtl_t     ctl,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              flagPin,
  input  logic              lowPin,
  output logic [DATA_W-1:0] coilEn,
  output logic [DATA_W-1:0] dataOut,
  output logic              flagEdge
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [DATA_W-1:0]      dataReg;
  logic [SYNC_STAGES-1:0] flagSync;
  logic [SYNC_STAGES-1:0] lowSync;
  logic                   flagPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataReg <= '0;
    else if (ctl.loadData) dataReg <= dataIn;
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            flagSync[0] <= 1'b0;
            lowSync[0]  <= 1'b0;
          end else begin
            flagSync[0] <= flagPin;
            lowSync[0]  <= lowPin;
          end
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            flagSync[s] <= 1'b0;
            lowSync[s]  <= 1'b0;
          end else begin
            flagSync[s] <= flagSync[s-1];
            lowSync[s]  <= lowSync[s-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagPrev <= 1'b0;
    else       flagPrev <= flagSync[LAST];
  end

  assign flagEdge = flagSync[LAST] & ~flagPrev;
  assign coilEn   = dataReg;

  always_comb begin
    dataOut = '0;
    if (ctl.readStatus) dataOut[STATUS_BIT] = lowSync[LAST];
  end

  // R1
  data_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadData |=> coilEn == $past(dataIn));

  // R4
  edge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagEdge |=> !flagEdge);
endmodule

// File: rtl/punch_control.sv
module punch_control (
  input  logic          clk,
  input  logic          rstN,
  input  logic          strbOut,
  input  logic          strbSetCtl,
  input  logic          strbClrCtl,
  input  logic          strbSetFlg,
  input  logic          strbClrFlg,
  input  logic          strbSkip,
  input  logic          strbLoad,
  input  logic          phaseT2,
  input  logic          flagEdge,
  output tpPkg::dpCtl_t dpCtl,
  output logic          punchCmd,
  output logic          skipOut,
  output logic          irqOut,
  output logic          flagOut
);
  logic ctlFf, punchFf, flagBuf, flagFf, irqFf;

  assign dpCtl.loadData   = strbOut;
  assign dpCtl.readStatus = strbLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlFf   <= 1'b0;
      punchFf <= 1'b0;
      flagBuf <= 1'b0;
      flagFf  <= 1'b0;
      irqFf   <= 1'b0;
    end else begin
      if (strbClrCtl)      ctlFf <= 1'b0;
      else if (strbSetCtl) ctlFf <= 1'b1;

      if (strbSetCtl)    punchFf <= 1'b1;
      else if (flagEdge) punchFf <= 1'b0;

      if (strbClrFlg) begin
        flagBuf <= 1'b0;
        flagFf  <= 1'b0;
      end else if (strbSetFlg || flagEdge) begin
        flagBuf <= 1'b1;
        flagFf  <= 1'b1;
      end

      if (strbClrCtl)                            irqFf <= 1'b0;
      else if (phaseT2 && flagBuf && ctlFf)      irqFf <= 1'b1;
    end
  end

  assign punchCmd = punchFf;
  assign skipOut  = strbSkip & flagFf;
  assign irqOut   = irqFf;
  assign flagOut  = irqFf;

  // R2
  set_ctl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strbSetCtl && !strbClrCtl) |=> (ctlFf && punchCmd));

  // R4
  punch_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagEdge && !strbSetCtl) |=> !punchCmd);

  // R5
  irq_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(phaseT2 && flagBuf && ctlFf));

  // R6
  clr_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strbClrFlg |=> (!flagFf && !flagBuf));
endmodule

// File: rtl/punch_iface.sv
module punch_iface #(
  parameter int DATA_W      = 8,
  parameter int STATUS_BIT  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strbOut,
  input  logic              strbSetCtl,
  input  logic              strbClrCtl,
  input  logic              strbSetFlg,
  input  logic              strbClrFlg,
  input  logic              strbSkip,
  input  logic              strbLoad,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              phaseT2,
  output logic [DATA_W-1:0] dataOut,
  output logic              skipOut,
  output logic              flagOut,
  output logic              irqOut,
  output logic [DATA_W-1:0] coilEn,
  output logic              punchCmd,
  input  logic              punchFlagIn,
  input  logic              lowTapeIn
);
  tpPkg::dpCtl_t dpCtl;
  logic          flagEdge;

  punch_control u_ctl (
    .clk, .rstN, .strbOut, .strbSetCtl, .strbClrCtl, .strbSetFlg,
    .strbClrFlg, .strbSkip, .strbLoad, .phaseT2, .flagEdge,
    .dpCtl, .punchCmd, .skipOut, .irqOut, .flagOut
  );

  punch_datapath #(
    .DATA_W(DATA_W), .STATUS_BIT(STATUS_BIT), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk, .rstN, .ctl(dpCtl), .dataIn,
    .flagPin(punchFlagIn), .lowPin(lowTapeIn),
    .coilEn, .dataOut, .flagEdge
  );
endmodule

// File: tb/punch_iface_bench.sv
module punch_iface_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strbOut = 0, strbSetCtl = 0, strbClrCtl = 0, strbSetFlg = 0;
  logic strbClrFlg = 0, strbSkip = 0, strbLoad = 0, phaseT2 = 0;
  logic [7:0] dataIn = '0;
  logic punchFlagIn = 0, lowTapeIn = 0;
  logic [7:0] dataOut, coilEn;
  logic skipOut, flagOut, irqOut, punchCmd;

  int nChecks = 0;
  int nFails  = 0;
  int wdog    = 0;

  // Reference state
  logic [7:0] mData;
  logic mCtl, mPunch, mBuf, mFlag, mIrq;
  logic f1, f2, f3, l1, l2;

  always #2.5 clk = ~clk;

  punch_iface u_punch_iface (
    .clk, .rstN, .strbOut, .strbSetCtl, .strbClrCtl, .strbSetFlg,
    .strbClrFlg, .strbSkip, .strbLoad, .dataIn, .phaseT2, .dataOut,
    .skipOut, .flagOut, .irqOut, .coilEn, .punchCmd, .punchFlagIn, .lowTapeIn
  );

  always @(posedge clk) begin
    wdog++;
    if (wdog > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expIn(logic ld, logic low);
    logic [7:0] v = '0;
    if (ld) v[5] = low;
    return v;
  endfunction

  task automatic modelReset();
    mData = '0; mCtl = 0; mPunch = 0; mBuf = 0; mFlag = 0; mIrq = 0;
    f1 = 0; f2 = 0; f3 = 0; l1 = 0; l2 = 0;
  endtask

  // Advance model by one clock edge using current inputs
  task automatic modelStep();
    logic e;
    e = f2 & ~f3;
    if (strbOut) mData = dataIn;
    if (strbClrCtl) mIrq = 0;
    else if (phaseT2 && mBuf && mCtl) mIrq = 1;
    if (strbClrCtl) mCtl = 0; else if (strbSetCtl) mCtl = 1;
    if (strbSetCtl) mPunch = 1; else if (e) mPunch = 0;
    if (strbClrFlg) begin mBuf = 0; mFlag = 0; end
    else if (strbSetFlg || e) begin mBuf = 1; mFlag = 1; end
    f3 = f2; f2 = f1; f1 = punchFlagIn;
    l2 = l1; l1 = lowTapeIn;
  endtask

  task automatic checkAll();
    chk("R1 coilEn", coilEn, mData);
    chk("R2/R4 punchCmd", {7'b0, punchCmd}, {7'b0, mPunch});
    chk("R5 irqOut", {7'b0, irqOut}, {7'b0, mIrq});
    chk("R5 flagOut", {7'b0, flagOut}, {7'b0, mIrq});
    chk("R7 skipOut", {7'b0, skipOut}, {7'b0, strbSkip & mFlag});
    chk("R8 dataOut", dataOut, expIn(strbLoad, l2));
  endtask

  task automatic clearStrb();
    strbOut = 0; strbSetCtl = 0; strbClrCtl = 0; strbSetFlg = 0;
    strbClrFlg = 0; strbSkip = 0; strbLoad = 0; phaseT2 = 0;
  endtask

  // Inputs already set at negedge: check, take edge, return at negedge
  task automatic step();
    #1 checkAll();
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  initial begin
    int seed;
    int hold;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    modelReset();
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 coilEn reset", coilEn, 8'h00);
    chk("R9 punchCmd reset", {7'b0, punchCmd}, 8'h00);
    chk("R9 irqOut reset", {7'b0, irqOut}, 8'h00);
    rstN = 1;
    @(negedge clk);

    // Directed: R1 load, R2 set control
    strbOut = 1; dataIn = 8'hA5; strbSetCtl = 1; step(); clearStrb();
    chk("R1 coil after load", coilEn, 8'hA5);
    chk("R2 punchCmd after set", {7'b0, punchCmd}, 8'h01);
    // R4 flag edge: pin high, three edges later punchCmd low
    punchFlagIn = 1; step(); step();
    chk("R4 punch still high before edge", {7'b0, punchCmd}, 8'h01);
    step();
    chk("R4 punch dropped", {7'b0, punchCmd}, 8'h00);
    // R7 skip answers with flag set
    strbSkip = 1; #1 chk("R7 skip with flag", {7'b0, skipOut}, 8'h01); step(); clearStrb();
    // R5 irq at T2
    phaseT2 = 1; step(); clearStrb();
    chk("R5 irq after T2", {7'b0, irqOut}, 8'h01);
    // R2 clear control drops irq
    strbClrCtl = 1; step(); clearStrb();
    chk("R2 irq cleared", {7'b0, irqOut}, 8'h00);
    // R3 set-control with clear-flag: no irq at T2
    strbSetCtl = 1; strbClrFlg = 1; step(); clearStrb();
    phaseT2 = 1; step(); step(); clearStrb();
    chk("R3 no irq after STC,C", {7'b0, irqOut}, 8'h00);
    strbSkip = 1; #1 chk("R3 flag cleared", {7'b0, skipOut}, 8'h00); step(); clearStrb();
    // R4 held high pin acts once: punch stays high
    step(); step();
    chk("R4 held pin no re-edge", {7'b0, punchCmd}, 8'h01);
    punchFlagIn = 0; step(); step(); step();
    // R6 clear wins over set
    strbSetFlg = 1; strbClrFlg = 1; step(); clearStrb();
    strbSkip = 1; #1 chk("R6 clear wins", {7'b0, skipOut}, 8'h00); step(); clearStrb();
    strbSetFlg = 1; step(); clearStrb();
    strbSkip = 1; #1 chk("R6 set flag", {7'b0, skipOut}, 8'h01); step(); clearStrb();
    // R8 low tape after two edges
    lowTapeIn = 1; strbLoad = 1; step(); step();
    #1 chk("R8 status bit", dataOut, 8'h20);
    step(); clearStrb(); lowTapeIn = 0;

    // Random phase
    hold = 0;
    for (int i = 0; i < 4000; i++) begin
      strbOut    = ($urandom % 8) == 0;
      strbSetCtl = ($urandom % 12) == 0;
      strbClrCtl = ($urandom % 16) == 0;
      strbSetFlg = ($urandom % 20) == 0;
      strbClrFlg = ($urandom % 14) == 0;
      strbSkip   = ($urandom % 3) == 0;
      strbLoad   = ($urandom % 3) == 0;
      phaseT2    = ($urandom % 4) == 0;
      dataIn     = 8'($urandom);
      if (hold == 0) begin
        punchFlagIn = ~punchFlagIn;
        hold = 3 + ($urandom % 10);
      end else hold--;
      if (($urandom % 25) == 0) lowTapeIn = ~lowTapeIn;
      step();
    end
    clearStrb();

    // R9 reset mid-run
    rstN = 0; modelReset(); #1;
    chk("R9 coil after reset", coilEn, 8'h00);
    chk("R9 irq after reset", {7'b0, irqOut}, 8'h00);
    @(negedge clk); rstN = 1; punchFlagIn = 0; lowTapeIn = 0;
    @(negedge clk);
    step();

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule